// File: doc/BRIEF.md
# Multiplicative Convergence Significand Divider

This block divides one normalized 24-bit significand by another. It uses multiplicative convergence rather than one quotient bit per cycle. A seed reciprocal of the divisor comes from a small table that is computed at elaboration time. The seed scales both operands. Four refinement passes then multiply the numerator and the denominator by the same factor, two minus the current denominator. This drives the denominator towards one, and the numerator becomes the quotient. In each pass the two products are independent and are formed in the same clock cycle.

Both significands are unsigned, with the hidden one at bit 23 and the fraction in bits 22..0. A one-cycle `start_i` pulse in the idle state captures the operands. Five clock edges later the quotient is presented and `done_o` pulses for one cycle. The quotient then holds until the next accepted start. Sign, exponent, rounding and packing are handled outside this block.

Top module: `sdiv_goldschmidt`

## Requirements
- R1: While reset is asserted and right after it is released, `done_o` is 0 and `quotient_o` is 0.
- R2: A start sampled high in the idle state is accepted on that clock edge. `done_o` is then high for exactly one cycle, the cycle that follows the fifth rising edge after the accepting edge: one seed step plus four refinement passes.
- R3: `quotient_o` is a 25-bit unsigned fixed-point value with bit 24 weighted 1 and bits 23..0 as fraction. When `done_o` is high it differs by at most 2 from floor(dividend·2^24 / divisor), taking both inputs as integers.
- R4: A start that arrives while an operation is in progress, including the cycle in which `done_o` is high, is ignored. It changes neither the result nor the timing of the operation already running.
- R5: After `done_o`, `quotient_o` holds its value until the next accepted start.
- R6: The seed table is indexed by divisor bits 22..15. After the seed step the scaled denominator lies within 2^-8 of one, for every table entry.
- R7: All internal values are unsigned fixed point with 2 integer bits and 30 fraction bits. Each product is truncated back to that format, and no product ever reaches or exceeds 4.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in the idle state only |
| dividend_i | input | 24 | Dividend significand, hidden one at bit 23 |
| divisor_i | input | 24 | Divisor significand, hidden one at bit 23 |
| quotient_o | output | 25 | Quotient, 1 integer bit and 24 fraction bits |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The divisor is swept across all 256 seed-table bins, once at the low edge and once at the high edge of each bin. These are the points where the seed error is largest, so a wrong table entry or index shows up there first. Equal operands and the extreme ratios (largest over smallest, smallest over largest) probe the top and bottom of the quotient range and the 1.0 boundary. Random operand pairs cover the general case. Runs with start held high, and start pulses in the middle of an operation with changed operands, separate a correct idle-only accept from a restart or an operand leak.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_seed_rom.sv
module sdiv_seed_rom #(
  parameter int IDX_W = 8,
  parameter int VAL_W = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [VAL_W-1:0] val_o
);
  localparam int DEPTH = 1 << IDX_W;

  // rounded reciprocal of the bin midpoint 1 + (i + 0.5) / DEPTH, scaled by 2^VAL_W
  function automatic logic [VAL_W-1:0] seed_val(input int i);
    logic [63:0] num;
    logic [63:0] den;
    logic [63:0] q;
    num = 64'd1 << (VAL_W + IDX_W + 2);
    den = (64'd1 << (IDX_W + 1)) + 64'(2 * i + 1);
    q   = ((num / den) + 64'd1) >> 1;
    return q[VAL_W-1:0];
  endfunction

  logic [VAL_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = seed_val(g);
  end

  assign val_o = table_q[idx_i];
endmodule

// File: rtl/sdiv_mul.sv
module sdiv_mul #(
  parameter int W      = 32,
  parameter int FRAC_W = 30
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic         ovf_o
);
  logic [2*W-1:0] full;
  logic [2*W-1:0] shifted;

  assign full    = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign shifted = full >> FRAC_W;
  assign p_o     = shifted[W-1:0];
  assign ovf_o   = |shifted[2*W-1:W];
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int STEPS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic iter_en_o,
  output logic seed_sel_o,
  output logic done_o
);
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  sdiv_state_e state_q;
  logic [STEP_W-1:0] step_q;

  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign iter_en_o  = (state_q == ST_RUN);
  assign seed_sel_o = iter_en_o && (step_q == '0);
  assign done_o     = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          step_q  <= '0;
        end
        ST_RUN: if (step_q == LAST) state_q <= ST_DONE;
                else                step_q  <= step_q + 1'b1;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_run_continues_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_en_o && step_q != LAST) |=> iter_en_o);
  assert_no_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !seed_sel_o);
endmodule

// File: rtl/sdiv_goldschmidt.sv
module sdiv_goldschmidt #(
  parameter int SIG_W     = 24,
  parameter int INT_W     = 2,
  parameter int FRAC_W    = 30,
  parameter int LUT_IDX_W = 8,
  parameter int LUT_W     = 10,
  parameter int ITERS     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SIG_W-1:0] dividend_i,
  input  logic [SIG_W-1:0] divisor_i,
  output logic [SIG_W:0]   quotient_o,
  output logic             done_o
);
  localparam int W     = INT_W + FRAC_W;
  localparam int STEPS = ITERS + 1;
  localparam int PAD   = FRAC_W - SIG_W + 1;
  localparam logic [W-1:0] ONE      = W'(1) << FRAC_W;
  localparam logic [W-1:0] TWO      = W'(1) << (FRAC_W + 1);
  localparam logic [W-1:0] SEED_TOL = W'(1) << (FRAC_W - LUT_IDX_W);

  logic load, iter_en, seed_sel;
  logic [W-1:0] n_q, d_q, factor, n_next, d_next, d_err, q_shift;
  logic [LUT_W-1:0] seed;
  logic ovf_n, ovf_d;

  sdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .iter_en_o(iter_en), .seed_sel_o(seed_sel), .done_o
  );

  // in the seed step d_q still holds the raw divisor
  sdiv_seed_rom #(.IDX_W(LUT_IDX_W), .VAL_W(LUT_W)) u_seed (
    .idx_i(d_q[FRAC_W-1 -: LUT_IDX_W]), .val_o(seed)
  );

  assign factor = seed_sel ? {{INT_W{1'b0}}, seed, {(FRAC_W-LUT_W){1'b0}}}
                           : TWO - d_q;

  sdiv_mul #(.W(W), .FRAC_W(FRAC_W)) u_mul_num (
    .a_i(n_q), .b_i(factor), .p_o(n_next), .ovf_o(ovf_n)
  );
  sdiv_mul #(.W(W), .FRAC_W(FRAC_W)) u_mul_den (
    .a_i(d_q), .b_i(factor), .p_o(d_next), .ovf_o(ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      d_q <= '0;
    end else if (load) begin
      n_q <= {{(INT_W-1){1'b0}}, dividend_i, {PAD{1'b0}}};
      d_q <= {{(INT_W-1){1'b0}}, divisor_i, {PAD{1'b0}}};
    end else if (iter_en) begin
      n_q <= n_next;
      d_q <= d_next;
    end
  end

  assign q_shift    = n_q >> (FRAC_W - SIG_W);
  assign quotient_o = (|q_shift[W-1:SIG_W+1]) ? {(SIG_W+1){1'b1}} : q_shift[SIG_W:0];
  assign d_err      = (d_q >= ONE) ? d_q - ONE : ONE - d_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_en |-> !(ovf_n || ovf_d));
  assert_seed_near_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_sel |=> (d_err < SEED_TOL));
  assert_hold_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(quotient_o));
endmodule

// File: tb/sdiv_goldschmidt_bench.sv
`timescale 1ns/1ps
module sdiv_goldschmidt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] x_in = 24'h800000;
  logic [23:0] y_in = 24'h800000;
  logic [24:0] quotient;
  logic done;

  int checks = 0;
  int failures = 0;

  sdiv_goldschmidt u_sdiv_goldschmidt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(x_in), .divisor_i(y_in),
    .quotient_o(quotient), .done_o(done)
  );

  always #4 clk = ~clk;

  // reference model: phase counter, 0 idle, 1..5 running, 6 done cycle
  int phase = 0;
  longint mx = 0, my = 0;
  bit have_result = 0;
  logic [24:0] held_q = '0;

  always @(posedge clk) begin
    if (!rst_n) phase = 0;
    else if (phase == 6) phase = 0;
    else if (phase == 0 && start) begin
      phase = 1; mx = longint'(x_in); my = longint'(y_in); have_result = 0;
    end else if (phase > 0) phase = phase + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint ex, diff;
      checks++;
      if (done !== (phase == 6)) begin
        failures++;
        $display("FAIL R2/R4 done timing: actual=%0b expected=%0b", done, phase == 6);
      end
      if (phase == 6) begin
        ex = (mx << 24) / my;
        diff = longint'(quotient) - ex;
        checks++;
        if (diff > 2 || diff < -2) begin
          failures++;
          $display("FAIL R3 quotient x=%h y=%h: actual=%h expected=%h", mx, my, quotient, ex);
        end
        held_q = quotient; have_result = 1;
      end else if (phase == 0 && have_result) begin
        checks++;
        if (quotient !== held_q) begin
          failures++;
          $display("FAIL R5 hold: actual=%h expected=%h", quotient, held_q);
        end
      end
    end
  end

  task automatic op(input logic [23:0] x, input logic [23:0] y);
    @(negedge clk); x_in = x; y_in = y; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  bit wd_fired = 0;
  initial begin
    #(8 * 150000);
    wd_fired = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || quotient !== '0) begin
          failures++;
          $display("FAIL R1 in reset: actual=%b/%h expected=0/0", done, quotient);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || quotient !== '0) begin
          failures++;
          $display("FAIL R1 after reset: actual=%b/%h expected=0/0", done, quotient);
        end
        // R3 corners: equal, extremes
        op(24'h800000, 24'h800000);
        op(24'hFFFFFF, 24'h800000);
        op(24'h800000, 24'hFFFFFF);
        op(24'hFFFFFF, 24'hFFFFFF);
        op(24'hC00000, 24'hA00000);
        // R6: every seed bin, both edges
        for (int i = 0; i < 256; i++) begin
          op(24'h800000 | 24'($urandom_range(0, 24'h7FFFFF)), {1'b1, 8'(i), 15'h0000});
          op(24'h800000 | 24'($urandom_range(0, 24'h7FFFFF)), {1'b1, 8'(i), 15'h7FFF});
        end
        // R3 random
        for (int i = 0; i < 300; i++)
          op(24'h800000 | 24'($urandom_range(0, 24'h7FFFFF)),
             24'h800000 | 24'($urandom_range(0, 24'h7FFFFF)));
        // R4: start mid-operation with changed operands
        for (int i = 0; i < 20; i++) begin
          @(negedge clk); x_in = 24'h900000 + 24'(i * 4099); y_in = 24'hF00000 - 24'(i * 777); start = 1'b1;
          @(negedge clk); start = 1'b0;
          @(negedge clk); x_in = 24'hFFFFFF; y_in = 24'h800001; start = 1'b1;
          @(negedge clk); start = 1'b0;
          repeat (5) @(negedge clk);
        end
        // R4: start held high, covers start during done cycle
        @(negedge clk); start = 1'b1;
        for (int i = 0; i < 60; i++) begin
          x_in = 24'h800000 | 24'($urandom_range(0, 24'h7FFFFF));
          y_in = 24'h800000 | 24'($urandom_range(0, 24'h7FFFFF));
          @(negedge clk);
        end
        start = 1'b0;
        repeat (10) @(negedge clk);
      end
      begin
        wait (wd_fired);
      end
    join_any
    if (wd_fired) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule